// File: doc/BRIEF.md
# Control Endpoint Register Block

This block is the endpoint-zero front end of a USB device controller. It sits between a packet-level serial engine and a processor register bus. The serial engine passes in the bytes of SETUP and OUT data packets with first/last markers, and IN-token requests. In return it receives the handshake verdict for each received packet, and either a stream of transmit bytes or a zero-length packet.

Firmware uses four byte-wide registers:

- a control/status register that carries the handshake flags;
- a receive data port that pops one byte per read;
- a receive byte count;
- a transmit data port.

A level interrupt stays high while any receive-side flag is pending. Firmware can arm a zero-length reply in advance during a host-to-device data stage. If the host then ends the data stage early with an IN status token, the block answers with that empty packet and raises two flags together, so firmware can tell the early status stage apart from an ordinary OUT packet.

Receive beats carry no back-pressure. A beat presented with `pk_valid` high is consumed in that cycle, whether it is stored or dropped. Transmit beats follow valid/ready rules:

- Once `tx_valid` rises, it stays high until a beat is taken with `tx_ready`.
- `tx_data`, `tx_last` and `tx_zlp` hold steady while `tx_valid` is high and `tx_ready` is low.
- A zero-length reply is a single beat with `tx_zlp` and `tx_last` both high.

Register map:

| Address | Register | Access |
|---|---|---|
| 0 | Control/status | read/write |
| 1 | Receive data | a read pops one byte |
| 2 | Receive byte count | read |
| 3 | Transmit data | write, ignored while sending; reads 0 |

Control/status bits:

| Bit | Name | Access |
|---|---|---|
| 0 | receive-ready | read-only |
| 1 | transmit-armed | write 1 to set |
| 5 | early-status | read-only |
| 6 | receive-done strobe | write 1 |
| 7 | early-status-ack strobe | write 1 |

Top module: `ep0_regif`

## Requirements
- R1: When the last byte of an accepted SETUP or OUT packet arrives, control/status bit 0 and `irq` rise on that same clock edge, and `hs_ack` pulses for one cycle during the following cycle.
- R2: Address 2 reads the number of unread receive bytes. Each read of address 1 returns the oldest stored byte and lowers the count by one. The buffer holds 8 bytes, and bytes beyond the eighth of a packet are dropped.
- R3: After reset, control/status, the byte count and `irq` read 0. Writing 1 to bit 6 clears bit 0, and with nothing else pending the register then reads 0x00 and `irq` falls. Bits 6 and 7 always read 0.
- R4: An OUT packet that starts while bit 0 is set is refused: `hs_nak` pulses in the cycle after its last byte, and the byte count and stored bytes stay unchanged.
- R5: Writing 1 to bit 1 sets it. An IN token that arrives while bit 1 is clear produces a one-cycle `in_nak` pulse in the next cycle, and `tx_valid` stays low.
- R6: An IN token with bit 1 set starts transmission on the next cycle. If the transmit buffer is empty, transmission is one beat with `tx_zlp` and `tx_last` high. Otherwise the stored bytes are sent in write order, with `tx_last` on the final one. Bit 1 clears once the last beat is taken.
- R7: A SETUP whose first byte has bit 7 at 0 opens a host-to-device stage. If a zero-length reply is sent during that stage, bits 0 and 5 set together, the register reads 0x21 and `irq` rises.
- R8: Writing 1 to bit 7 clears bit 5. Writing 0xC0 clears bits 0 and 5 in one write.
- R9: A SETUP packet is always accepted, even while bit 0 is set. It empties the transmit buffer, clears bit 1 and leaves only its own bytes in the receive buffer.
- R10: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data`, `tx_last` and `tx_zlp` hold their values.
- R11: After bit 0 has been cleared, each following OUT packet is accepted and raises its own interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pk_valid | input | 1 | Received byte present this cycle |
| pk_first | input | 1 | Byte is the first of its packet |
| pk_last | input | 1 | Byte is the last of its packet |
| pk_setup | input | 1 | Packet is a SETUP (valid with every beat) |
| pk_data | input | 8 | Received byte |
| hs_ack | output | 1 | Packet accepted; one-cycle pulse |
| hs_nak | output | 1 | Packet refused; one-cycle pulse |
| tok_in | input | 1 | IN token received; one-cycle pulse |
| in_nak | output | 1 | IN token refused; one-cycle pulse |
| tx_valid | output | 1 | Transmit beat present |
| tx_ready | input | 1 | Serial engine takes the beat |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Final beat of the reply |
| tx_zlp | output | 1 | Beat stands for a zero-length packet |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| irq | output | 1 | Level interrupt: receive-ready or early-status pending |

## Verification
Properties checked on every cycle:

- the receive buffer never counts past its depth;
- a pop lowers the count by exactly one;
- the early-status flag never rises without receive-ready;
- an IN refusal only follows a cycle in which the transmit-armed bit was clear;
- transmit beats stay frozen under back-pressure, and a zero-length beat is always marked last.

Some behaviours only the scenarios can show:

- refusing an OUT packet while data is still unread;
- a SETUP that overrides an armed, loaded transmit buffer;
- the early IN status token that turns the register into 0x21;
- bytes dropped beyond the eighth.

Each of these is compared against a behavioural model on every clock and by explicit register reads.

// File: rtl/ep0_pkg.sv
package ep0_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_CSR    = 2'd0;
  localparam logic [ADDR_W-1:0] A_RXDATA = 2'd1;
  localparam logic [ADDR_W-1:0] A_RXCNT  = 2'd2;
  localparam logic [ADDR_W-1:0] A_TXDATA = 2'd3;

  localparam int B_RXRDY  = 0;
  localparam int B_TXARM  = 1;
  localparam int B_EARLY  = 5;
  localparam int B_RXDONE = 6;
  localparam int B_EACK   = 7;

  typedef enum logic {TX_IDLE, TX_SEND} tx_state_e;
endpackage

// File: rtl/ep0_bytefifo.sv
module ep0_bytefifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             pop,
  output logic [W-1:0]     dout,
  output logic [CNT_W-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_q, wr_q;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign push_ok = push && (count < CNT_W'(DEPTH));
  assign pop_ok  = pop && (count != '0);
  assign dout    = mem[rd_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      count <= '0;
    end else if (flush) begin
      rd_q  <= '0;
      wr_q  <= push ? AW'(1) : '0;
      count <= push ? CNT_W'(1) : '0;
    end else begin
      if (push_ok) wr_q <= nxt(wr_q);
      if (pop_ok)  rd_q <= nxt(rd_q);
      count <= count + CNT_W'(push_ok) - CNT_W'(pop_ok);
    end
  end

  always_ff @(posedge clk) begin
    if (flush && push)  mem[0]    <= din;
    else if (push_ok)   mem[wr_q] <= din;
  end

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  p_pop_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && count != '0 && !push && !flush) |=> count == $past(count) - CNT_W'(1));
endmodule

// File: rtl/ep0_rx.sv
module ep0_rx #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pk_valid,
  input  logic         pk_first,
  input  logic         pk_last,
  input  logic         pk_setup,
  input  logic [W-1:0] pk_data,
  input  logic         rxrdy,
  output logic         setup_start,
  output logic         setup_h2d,
  output logic         buf_push,
  output logic         set_rxrdy,
  output logic         hs_ack,
  output logic         hs_nak
);
  logic take_q, take_now;

  assign take_now    = pk_first ? (pk_setup || !rxrdy) : take_q;
  assign setup_start = pk_valid && pk_first && pk_setup;
  assign setup_h2d   = !pk_data[W-1];
  assign buf_push    = pk_valid && take_now;
  assign set_rxrdy   = pk_valid && pk_last && take_now;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      take_q <= 1'b0;
      hs_ack <= 1'b0;
      hs_nak <= 1'b0;
    end else begin
      if (pk_valid && pk_first) take_q <= take_now;
      hs_ack <= set_rxrdy;
      hs_nak <= pk_valid && pk_last && !take_now;
    end
  end

  p_one_verdict_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_ack && hs_nak));
endmodule

// File: rtl/ep0_tx.sv
module ep0_tx
  import ep0_pkg::*;
#(
  parameter int W     = 8,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tok_in,
  input  logic             armed,
  input  logic [CNT_W-1:0] fifo_count,
  input  logic [W-1:0]     fifo_dout,
  output logic             fifo_pop,
  output logic             busy,
  output logic             done,
  output logic             done_zlp,
  output logic             in_nak,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic [W-1:0]     tx_data,
  output logic             tx_last,
  output logic             tx_zlp
);
  tx_state_e st_q;
  logic      zlp_q;

  assign busy     = (st_q == TX_SEND);
  assign tx_valid = busy;
  assign tx_zlp   = busy && zlp_q;
  assign tx_data  = (busy && !zlp_q) ? fifo_dout : '0;
  assign tx_last  = busy && (zlp_q || fifo_count == CNT_W'(1));
  assign fifo_pop = busy && tx_ready && !zlp_q;
  assign done     = busy && tx_ready && tx_last;
  assign done_zlp = done && zlp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= TX_IDLE;
      zlp_q  <= 1'b0;
      in_nak <= 1'b0;
    end else begin
      in_nak <= 1'b0;
      if (st_q == TX_IDLE) begin
        if (tok_in) begin
          if (armed) begin
            st_q  <= TX_SEND;
            zlp_q <= (fifo_count == '0);
          end else begin
            in_nak <= 1'b1;
          end
        end
      end else if (done) begin
        st_q  <= TX_IDLE;
        zlp_q <= 1'b0;
      end
    end
  end

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last) && $stable(tx_zlp)));

  p_zlp_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_zlp |-> tx_last);
endmodule

// File: rtl/ep0_regif.sv
module ep0_regif
  import ep0_pkg::*;
#(
  parameter int RX_DEPTH = 8,
  parameter int TX_DEPTH = 8,
  localparam int RX_CW = $clog2(RX_DEPTH + 1),
  localparam int TX_CW = $clog2(TX_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pk_valid,
  input  logic              pk_first,
  input  logic              pk_last,
  input  logic              pk_setup,
  input  logic [BYTE_W-1:0] pk_data,
  output logic              hs_ack,
  output logic              hs_nak,
  input  logic              tok_in,
  output logic              in_nak,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [BYTE_W-1:0] tx_data,
  output logic              tx_last,
  output logic              tx_zlp,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              irq
);
  logic rxrdy_q, early_q, armed_q, h2d_q;
  logic setup_start, setup_h2d, rx_push, set_rxrdy;
  logic [BYTE_W-1:0] rx_dout, tx_dout;
  logic [RX_CW-1:0]  rx_count;
  logic [TX_CW-1:0]  tx_count;
  logic tx_pop, tx_busy, tx_done, tx_done_zlp;
  logic csr_wr, rx_rd, tx_wr, early_evt;

  assign csr_wr    = bus_sel && bus_wr && (bus_addr == A_CSR);
  assign tx_wr     = bus_sel && bus_wr && (bus_addr == A_TXDATA) && !tx_busy;
  assign rx_rd     = bus_sel && !bus_wr && (bus_addr == A_RXDATA);
  assign early_evt = tx_done_zlp && h2d_q;

  ep0_rx #(.W(BYTE_W)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .pk_valid(pk_valid), .pk_first(pk_first), .pk_last(pk_last),
    .pk_setup(pk_setup), .pk_data(pk_data), .rxrdy(rxrdy_q),
    .setup_start(setup_start), .setup_h2d(setup_h2d),
    .buf_push(rx_push), .set_rxrdy(set_rxrdy),
    .hs_ack(hs_ack), .hs_nak(hs_nak)
  );

  ep0_bytefifo #(.W(BYTE_W), .DEPTH(RX_DEPTH)) u_rxbuf (
    .clk(clk), .rst_n(rst_n), .flush(setup_start),
    .push(rx_push), .din(pk_data), .pop(rx_rd),
    .dout(rx_dout), .count(rx_count)
  );

  ep0_bytefifo #(.W(BYTE_W), .DEPTH(TX_DEPTH)) u_txbuf (
    .clk(clk), .rst_n(rst_n), .flush(setup_start),
    .push(tx_wr), .din(bus_wdata), .pop(tx_pop),
    .dout(tx_dout), .count(tx_count)
  );

  ep0_tx #(.W(BYTE_W), .CNT_W(TX_CW)) u_tx (
    .clk(clk), .rst_n(rst_n), .tok_in(tok_in), .armed(armed_q),
    .fifo_count(tx_count), .fifo_dout(tx_dout), .fifo_pop(tx_pop),
    .busy(tx_busy), .done(tx_done), .done_zlp(tx_done_zlp),
    .in_nak(in_nak), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_last(tx_last), .tx_zlp(tx_zlp)
  );

  // Flag updates: a firmware strobe clears first, hardware events override.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rxrdy_q <= 1'b0;
      early_q <= 1'b0;
      armed_q <= 1'b0;
      h2d_q   <= 1'b0;
    end else begin
      if (csr_wr && bus_wdata[B_RXDONE]) rxrdy_q <= 1'b0;
      if (setup_start)                   rxrdy_q <= 1'b0;
      if (set_rxrdy || early_evt)        rxrdy_q <= 1'b1;

      if (csr_wr && bus_wdata[B_EACK]) early_q <= 1'b0;
      if (early_evt)                   early_q <= 1'b1;

      if (csr_wr && bus_wdata[B_TXARM]) armed_q <= 1'b1;
      if (tx_done || setup_start)       armed_q <= 1'b0;

      if (setup_start)    h2d_q <= setup_h2d;
      else if (early_evt) h2d_q <= 1'b0;
    end
  end

  assign irq = rxrdy_q || early_q;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CSR: begin
        bus_rdata[B_RXRDY] = rxrdy_q;
        bus_rdata[B_TXARM] = armed_q;
        bus_rdata[B_EARLY] = early_q;
      end
      A_RXDATA: bus_rdata = (rx_count != '0) ? rx_dout : '0;
      A_RXCNT:  bus_rdata = BYTE_W'(rx_count);
      default:  bus_rdata = '0;
    endcase
  end

  p_early_with_rdy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(early_q) |-> rxrdy_q);

  p_nak_unarmed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_nak |-> !$past(armed_q));
endmodule

// File: tb/test_ep0_regif.sv
module test_ep0_regif;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pk_valid = 0, pk_first = 0, pk_last = 0, pk_setup = 0;
  logic [7:0] pk_data = '0;
  logic hs_ack, hs_nak, in_nak, tx_valid, tx_last, tx_zlp, irq;
  logic tok_in = 0, tx_ready = 0;
  logic [7:0] tx_data, bus_rdata;
  logic bus_sel = 0, bus_wr = 0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  ep0_regif i_ep0_regif (
    .clk(clk), .rst_n(rst_n),
    .pk_valid(pk_valid), .pk_first(pk_first), .pk_last(pk_last),
    .pk_setup(pk_setup), .pk_data(pk_data),
    .hs_ack(hs_ack), .hs_nak(hs_nak), .tok_in(tok_in), .in_nak(in_nak),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_last(tx_last), .tx_zlp(tx_zlp),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // Behavioural reference model
  bit m_rdy, m_early, m_arm, m_h2d, m_take, m_send, m_zlp;
  bit m_ack, m_nak, m_innak;
  byte unsigned rxq[$];
  byte unsigned txq[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rdy = 0; m_early = 0; m_arm = 0; m_h2d = 0; m_take = 0;
      m_send = 0; m_zlp = 0; m_ack = 0; m_nak = 0; m_innak = 0;
      rxq.delete(); txq.delete();
    end else begin
      bit take;
      bit done;
      m_ack = 0; m_nak = 0; m_innak = 0; done = 0;
      if (bus_sel && !bus_wr && bus_addr == 2'd1 && rxq.size() > 0) void'(rxq.pop_front());
      if (bus_sel && bus_wr && bus_addr == 2'd0) begin
        if (bus_wdata[6]) m_rdy = 0;
        if (bus_wdata[7]) m_early = 0;
        if (bus_wdata[1]) m_arm = 1;
      end
      if (bus_sel && bus_wr && bus_addr == 2'd3 && !m_send && txq.size() < 8)
        txq.push_back(bus_wdata);
      if (!m_send) begin
        if (tok_in) begin
          if (m_arm) begin m_send = 1; m_zlp = (txq.size() == 0); end
          else m_innak = 1;
        end
      end else if (tx_ready) begin
        if (m_zlp) done = 1;
        else begin
          void'(txq.pop_front());
          if (txq.size() == 0) done = 1;
        end
        if (done) begin
          m_send = 0; m_arm = 0;
          if (m_zlp && m_h2d) begin m_rdy = 1; m_early = 1; m_h2d = 0; end
          m_zlp = 0;
        end
      end
      if (pk_valid) begin
        take = pk_first ? (pk_setup || !m_rdy) : m_take;
        if (pk_first) m_take = take;
        if (pk_first && pk_setup) begin
          rxq.delete(); txq.delete(); m_arm = 0; m_rdy = 0; m_h2d = !pk_data[7];
        end
        if (take && rxq.size() < 8) rxq.push_back(pk_data);
        if (pk_last) begin
          if (take) begin m_rdy = 1; m_ack = 1; end
          else m_nak = 1;
        end
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Cycle compare of every output against the model (R1 R5 R6 R10)
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R1 irq/model", irq, m_rdy | m_early);
      check("R1 hs_ack/model", hs_ack, m_ack);
      check("R4 hs_nak/model", hs_nak, m_nak);
      check("R5 in_nak/model", in_nak, m_innak);
      check("R6 tx_valid/model", tx_valid, m_send);
      if (m_send) begin
        check("R6 tx_zlp/model", tx_zlp, m_zlp);
        check("R6 tx_last/model", tx_last, m_zlp || txq.size() == 1);
        if (!m_zlp) check("R10 tx_data/model", tx_data, txq[0]);
      end
    end
  end

  task automatic send_pkt(input bit setup, input int n, input logic [7:0] b0, input logic [7:0] base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pk_valid = 1; pk_first = (i == 0); pk_last = (i == n - 1);
      pk_setup = setup; pk_data = (i == 0) ? b0 : base + 8'(i);
    end
    @(negedge clk);
    pk_valid = 0; pk_first = 0; pk_last = 0; pk_setup = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    check(tag, v, exp);
  endtask

  task automatic token;
    @(negedge clk); tok_in = 1;
    @(negedge clk); tok_in = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !finished) begin
      finished = 1;
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd_chk("R3 reset csr", 2'd0, 8'h00);
    rd_chk("R3 reset count", 2'd2, 8'h00);
    check("R3 reset irq", irq, 0);

    // Host-to-device SETUP, 8 bytes
    send_pkt(1, 8, 8'h00, 8'h10);
    check("R1 irq after setup", irq, 1);
    rd_chk("R1 csr after setup", 2'd0, 8'h01);
    rd_chk("R2 count 8", 2'd2, 8'd8);
    for (int i = 0; i < 8; i++) begin
      rd_chk("R2 rx byte", 2'd1, (i == 0) ? 8'h00 : 8'h10 + 8'(i));
      if (i == 2) rd_chk("R2 count after 3 pops", 2'd2, 8'd5);
    end
    rd_chk("R2 count empty", 2'd2, 8'd0);
    wr(2'd0, 8'h40);
    rd_chk("R3 csr cleared", 2'd0, 8'h00);
    check("R3 irq low", irq, 0);
    wr(2'd0, 8'hFF & 8'h02);
    rd_chk("R5 armed bit", 2'd0, 8'h02);

    // OUT data, then refused OUT while unread
    send_pkt(0, 3, 8'hA0, 8'hA0);
    rd_chk("R11 csr after OUT", 2'd0, 8'h03);
    send_pkt(0, 2, 8'hE0, 8'hE0);
    rd_chk("R4 count unchanged", 2'd2, 8'd3);
    wr(2'd0, 8'h40);
    for (int i = 0; i < 3; i++) rd_chk("R4 bytes unchanged", 2'd1, 8'hA0 + 8'(i));
    send_pkt(0, 2, 8'hB0, 8'hB0);
    check("R11 second OUT irq", irq, 1);
    rd_chk("R11 second OUT count", 2'd2, 8'd2);
    rd_chk("R11 second OUT byte", 2'd1, 8'hB0);
    rd_chk("R11 second OUT byte", 2'd1, 8'hB1);
    wr(2'd0, 8'h40);

    // Early status IN: zero-length reply under back-pressure
    token;
    check("R6 zlp valid", tx_valid, 1);
    check("R6 zlp flag", tx_zlp, 1);
    check("R6 zlp last", tx_last, 1);
    repeat (2) @(negedge clk);
    check("R10 held valid", tx_valid, 1);
    tx_ready = 1;
    @(negedge clk);
    tx_ready = 0;
    check("R7 irq after early status", irq, 1);
    rd_chk("R7 csr 0x21", 2'd0, 8'h21);
    wr(2'd0, 8'h80);
    rd_chk("R8 early cleared", 2'd0, 8'h01);
    wr(2'd0, 8'h40);
    rd_chk("R3 all clear", 2'd0, 8'h00);

    // IN token while unarmed
    token;
    check("R5 in_nak", in_nak, 1);
    check("R5 no tx", tx_valid, 0);

    // Device-to-host SETUP, then 3-byte IN reply
    send_pkt(1, 8, 8'h80, 8'h30);
    wr(2'd0, 8'h40);
    wr(2'd3, 8'h91); wr(2'd3, 8'h92); wr(2'd3, 8'h93);
    wr(2'd0, 8'h02);
    token;
    tx_ready = 1;
    for (int k = 0; k < 3; k++) begin
      check("R6 tx byte", tx_data, 8'h91 + 8'(k));
      check("R6 tx last", tx_last, (k == 2));
      @(negedge clk);
    end
    tx_ready = 0;
    check("R6 done", tx_valid, 0);
    rd_chk("R6 armed cleared", 2'd0, 8'h00);

    // SETUP overriding pending data and armed buffer
    send_pkt(1, 2, 8'h21, 8'h21);
    wr(2'd3, 8'hAA); wr(2'd3, 8'hBB);
    wr(2'd0, 8'h02);
    rd_chk("R9 csr before", 2'd0, 8'h03);
    send_pkt(1, 2, 8'h40, 8'h60);
    rd_chk("R9 csr after setup", 2'd0, 8'h01);
    rd_chk("R9 count", 2'd2, 8'd2);
    rd_chk("R9 byte0", 2'd1, 8'h40);
    rd_chk("R9 byte1", 2'd1, 8'h61);
    token;
    check("R9 arm dropped", in_nak, 1);
    wr(2'd0, 8'h40);
    wr(2'd0, 8'h02);
    token;
    check("R9 tx flushed", tx_zlp, 1);
    tx_ready = 1;
    @(negedge clk);
    tx_ready = 0;
    rd_chk("R7 csr 0x21 again", 2'd0, 8'h21);
    wr(2'd0, 8'hC0);
    rd_chk("R8 both cleared", 2'd0, 8'h00);
    check("R8 irq low", irq, 0);

    // Overlong OUT packet
    send_pkt(0, 10, 8'h50, 8'h50);
    rd_chk("R2 overflow count", 2'd2, 8'd8);
    rd_chk("R2 overflow first", 2'd1, 8'h50);

    repeat (2) @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule